// File: doc/BRIEF.md
# Global Shutter Exposure Timer

This block times the exposure window of an image sensor that integrates all pixels at once. A one-cycle shutter-start pulse captures the programmed exposure length and a two-bit granularity code. A prescaler then turns the system clock into a slower tick. A 12-bit counter counts those ticks until it reaches the captured length. At that point the block raises a one-cycle time-out pulse, which the surrounding logic turns into the stop-of-integration event.

The block measures exactly one exposure per start. After the time-out it stays idle until the next start. A start that arrives mid-exposure abandons the current measurement and begins a new one from zero. Lengths below the permitted minimum of 10 are raised to 10 when they are captured.

Top module: `gst_integration_timer`

## Requirements
- R1: After reset `timeout_o` is 0, and it stays 0 for as long as no shutter-start arrives.
- R2: With captured length N and divide factor F, `timeout_o` is 1 in the cycle that begins N*F clock edges after the edge that sampled `shutter_start_i` high. It is 0 in every cycle before that.
- R3: The `gran_sel_i` code selects the divide factor: 0 gives 1, 1 gives 4, 2 gives 16, and 3 gives 256.
- R4: A value of `int_time_i` below 10 is captured as 10. Values from 10 to 4095 are captured unchanged.
- R5: `timeout_o` stays high for exactly one cycle. The block then produces no further pulse until a new shutter-start arrives.
- R6: A shutter-start during an exposure restarts both the prescaler and the counter. The only pulse is the one timed from the latest start.
- R7: `int_time_i` and `gran_sel_i` are sampled only at a shutter-start. Changing them during an exposure does not move the time-out.
- R8: The full 12-bit length 4095 is timed without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shutter_start_i | input | 1 | One-cycle pulse that starts or restarts an exposure |
| gran_sel_i | input | 2 | Granularity code, sampled at start |
| int_time_i | input | 12 | Exposure length in granulated ticks, sampled at start |
| timeout_o | output | 1 | One-cycle pulse at the end of the exposure |

## Verification
The bench sweeps every length from 0 to 15 against the three smaller divide factors. This separates the clamping of short lengths from lengths that are taken as given, and it exposes any off-by-one in the prescaler or the counter as a wrong pulse cycle. Two longer cases exercise the widest factor and the full 12-bit length. Separate runs change the inputs in the middle of an exposure and restart it early. These show whether the values are sampled only at the start and whether an early restart drops the old measurement. After each pulse the bench watches an idle window to confirm that no second pulse appears.

// File: rtl/gst_pkg.sv
package gst_pkg;
   typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_state_t;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/gst_prescaler.sv
module gst_prescaler #(
   parameter int PRE_W = 8,
   parameter int SH0   = 0,
   parameter int SH1   = 2,
   parameter int SH2   = 4,
   parameter int SH3   = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [1:0] sel_i,
   input  logic       run_i,
   output logic       tick_o
);
   localparam int MAX_SH = int'(gst_pkg::max_of4(SH0, SH1, SH2, SH3));

   generate
      if (PRE_W < 1 || MAX_SH > PRE_W) begin : g_bad_cfg
         $error("gst_prescaler: shift exceeds prescaler width");
      end
      if (MAX_SH == 0) begin : g_no_div
         assign tick_o = run_i;
      end else begin : g_div
         localparam logic [PRE_W-1:0] T0 = PRE_W'((1 << SH0) - 1);
         localparam logic [PRE_W-1:0] T1 = PRE_W'((1 << SH1) - 1);
         localparam logic [PRE_W-1:0] T2 = PRE_W'((1 << SH2) - 1);
         localparam logic [PRE_W-1:0] T3 = PRE_W'((1 << SH3) - 1);
         logic [1:0]       sel_q;
         logic [PRE_W-1:0] pre_q;
         logic [PRE_W-1:0] term;

         always_comb begin
            case (sel_q)
               2'd0:    term = T0;
               2'd1:    term = T1;
               2'd2:    term = T2;
               default: term = T3;
            endcase
         end

         assign tick_o = run_i && (pre_q == term);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sel_q <= 2'd0;
               pre_q <= '0;
            end else if (load_i) begin
               sel_q <= sel_i;
               pre_q <= '0;
            end else if (run_i) begin
               pre_q <= (pre_q == term) ? '0 : pre_q + 1'b1;
            end
         end

         // R3: the prescale phase never passes the selected divide terminal
         assert_prescale_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= term);
         // R6: a load restarts the prescale phase
         assert_prescale_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> pre_q == '0);
      end
   endgenerate
endmodule

// File: rtl/gst_counter.sv
module gst_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             done_o
);
   logic [CNT_W-1:0] count_q;

   assign done_o = tick_i && (count_q == limit_i - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (clear_i) count_q <= '0;
      else if (tick_i)  count_q <= done_o ? '0 : count_q + 1'b1;
   end

   // R8: the count stays below the captured limit and never wraps
   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |-> count_q < limit_i);
   // R2: a tick that is not terminal advances the count by one
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !done_o && !clear_i) |=> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/gst_integration_timer.sv
module gst_integration_timer #(
   parameter int CNT_W     = 12,
   parameter int MIN_COUNT = 10,
   parameter int PRE_W     = 8,
   parameter int SH0       = 0,
   parameter int SH1       = 2,
   parameter int SH2       = 4,
   parameter int SH3       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shutter_start_i,
   input  logic [1:0]       gran_sel_i,
   input  logic [CNT_W-1:0] int_time_i,
   output logic             timeout_o
);
   import gst_pkg::*;

   localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_COUNT);

   generate
      if (MIN_COUNT < 1 || MIN_COUNT >= (1 << CNT_W)) begin : g_bad_min
         $error("gst_integration_timer: MIN_COUNT out of range");
      end
   endgenerate

   run_state_t       state_q;
   logic [CNT_W-1:0] limit_q;
   logic             timeout_q;
   logic             run;
   logic             tick;
   logic             done;

   assign run       = (state_q == ST_RUN) && !shutter_start_i;
   assign timeout_o = timeout_q;

   gst_prescaler #(.PRE_W(PRE_W), .SH0(SH0), .SH1(SH1), .SH2(SH2), .SH3(SH3)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (shutter_start_i),
      .sel_i  (gran_sel_i),
      .run_i  (run),
      .tick_o (tick)
   );

   gst_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (shutter_start_i),
      .tick_i  (tick),
      .limit_i (limit_q),
      .done_o  (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         limit_q   <= MIN_VAL;
         timeout_q <= 1'b0;
      end else begin
         timeout_q <= done && !shutter_start_i;
         if (shutter_start_i) begin
            state_q <= ST_RUN;
            limit_q <= (int_time_i < MIN_VAL) ? MIN_VAL : int_time_i;
         end else if (done) begin
            state_q <= ST_IDLE;
         end
      end
   end

   // R5: the pulse lasts one cycle
   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);
   // R5: the timer is idle while the pulse is high
   assert_idle_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> state_q == ST_IDLE);
   // R6: a start always leaves the timer running with no pulse
   assert_start_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shutter_start_i |=> (state_q == ST_RUN && !timeout_o));
   // R4: the captured length is never below the minimum
   assert_min_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      limit_q >= MIN_VAL);
   // R1: no pulse can come from the idle state
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !shutter_start_i) |=> !timeout_o);
endmodule

// File: tb/gst_integration_timer_test.sv
module gst_integration_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  gsel = 2'd0;
   logic [11:0] itime = 12'd0;
   logic        timeout;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   gst_integration_timer uut (
      .clk             (clk),
      .rst_n           (rst_n),
      .shutter_start_i (start),
      .gran_sel_i      (gsel),
      .int_time_i      (itime),
      .timeout_o       (timeout)
   );

   function automatic int factor(input int g);
      case (g)
         0: return 1;
         1: return 4;
         2: return 16;
         default: return 256;
      endcase
   endfunction

   function automatic int eff(input int n);
      return (n < 10) ? 10 : n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_start(input int n, input int g);
      @(negedge clk);
      start = 1'b1;
      itime = 12'(n);
      gsel  = 2'(g);
      @(negedge clk);
      start = 1'b0;
   endtask

   // Start, then find the pulse. The negedge right after the start edge is index 0.
   // If disturb is set, the inputs change at index 3 to values that would shift the pulse.
   task automatic measure(input int n, input int g, input bit disturb, input string req);
      int exp;
      int seen;
      exp  = eff(n) * factor(g);
      seen = -1;
      pulse_start(n, g);
      for (int j = 0; j <= exp + 2; j++) begin
         if (timeout && seen < 0) seen = j;
         if (disturb && j == 3) begin
            itime = 12'd15;
            gsel  = 2'(g ^ 1);
         end
         @(negedge clk);
      end
      check(seen == exp, req, seen, exp);
      // R5: the pulse has gone, and no second pulse appears in an idle window
      seen = 0;
      for (int k = 0; k < 12; k++) begin
         if (timeout) seen++;
         @(negedge clk);
      end
      check(seen == 0, "R5", seen, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int seen;
      repeat (3) @(negedge clk);
      check(timeout == 1'b0, "R1", int'(timeout), 0);
      rst_n = 1'b1;
      seen = 0;
      for (int k = 0; k < 30; k++) begin
         if (timeout) seen++;
         @(negedge clk);
      end
      check(seen == 0, "R1", seen, 0);

      // R2 R3 R4: sweep lengths 0..15 over factors 1, 4 and 16
      for (int g = 0; g < 3; g++)
         for (int n = 0; n < 16; n++)
            measure(n, g, 1'b0, (n < 10) ? "R4" : "R2/R3");

      // R3: the widest factor
      measure(10, 3, 1'b0, "R3");
      // R8: the full 12-bit length
      measure(4095, 0, 1'b0, "R8");
      // R7: input changes during the exposure
      measure(12, 1, 1'b1, "R7");
      measure(20, 0, 1'b1, "R7");

      // R6: restart after 7 cycles; only the second start sets the time
      pulse_start(40, 0);
      repeat (6) @(negedge clk);
      begin
         int exp2;
         exp2 = 11 * 4;
         seen = -1;
         pulse_start(11, 1);
         for (int j = 0; j <= exp2 + 2; j++) begin
            if (timeout && seen < 0) seen = j;
            @(negedge clk);
         end
         check(seen == exp2, "R6", seen, exp2);
         seen = 0;
         for (int k = 0; k < 60; k++) begin
            if (timeout) seen++;
            @(negedge clk);
         end
         check(seen == 0, "R6", seen, 0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule